// File: doc/BRIEF.md
# SPI Register Slave with Deferred Readback

This block is the device end of a 24-bit serial register protocol. A host lowers the chip select, clocks in one command byte and one 16-bit data word, and raises chip select again. The block counts the falling clock edges inside that window. It accepts the frame only when the count is exactly 24. It then either writes the word into a small bank of 16-bit registers or arranges for the addressed register to be returned.

A read does not answer within its own frame. The reply is shifted out on the serial output during the next frame, whatever that next frame carries. The serial side runs on the serial clock, with its state cleared while chip select is high. Each accepted frame crosses into the system clock with a toggle, two synchronizer flops and an edge detector. The system side holds the register bank and decodes frames with a three-state sequencer:

- `ST_IDLE` waits for a frame pulse and moves to `ST_LATCH`.
- `ST_LATCH` copies the captured frame and always moves to `ST_APPLY`.
- `ST_APPLY` performs the write or loads the readback word, then always returns to `ST_IDLE`.

The system side exposes every register on a flat output bus, and it exposes an active flag taken from the configuration register.

The host must keep chip select high for at least 8 system clock cycles between frames.

Top module: `spi_rs_slave`

## Requirements
- R1: A frame is 24 bits sent MSB first and sampled on falling SCLK edges. Bit 23 is the read flag (1 = read). Bits 22:16 are the register address. Bits 15:0 are the write data.
- R2: After reset the registers hold these values: 0x03 = 0x0A24, 0x04 = 0x7F00, 0x09 = 0xFFFF, data registers = 0x0000. `dev_active` is low and `sdo_oe` is low.
- R3: A write frame of exactly 24 edges updates the addressed register. The new value is visible on `regs_o` within 8 system clock cycles after chip select rises.
- R4: A frame with any other number of falling edges (0, 23, 25 and so on) changes no register and leaves the pending readback word unchanged.
- R5: After a valid read frame, the next frame carries {read command byte, register value} on `sdo`. Bit 23 is presented from the start of the frame, and the output moves down one bit after each falling SCLK edge.
- R6: After a valid write frame, the next frame carries all zeros on `sdo`.
- R7: Addresses other than 0x03, 0x04, 0x09 and the data registers 0x14 to 0x17 read back a data field of 0x0000. Writes to those addresses are discarded.
- R8: `sdo_oe` is high only while `cs_n` is low and bit 2 (serial output enable) of register 0x03 is set.
- R9: `dev_active` is high exactly when bit 5 (power-down) of register 0x03 is clear. For example, writing 0x0A84 to 0x03 makes it high.
- R10: `regs_o` carries 16-bit slices starting at the least significant bit, in this order: 0x03, 0x04, 0x09, then the data registers in ascending address order.
- R11: Idle-low (mode 1) and idle-high (mode 2) serial clocks are both accepted with identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output-enable for the sdo pad driver |
| regs_o | output | 16*(3+NUM_CH) | All registers, flattened |
| dev_active | output | 1 | Device out of power-down |

## Verification
A miscounted edge counter shows up in one of two ways on the register bus. Either a short or long frame alters a register, or a proper frame is lost, and both are visible within 8 system cycles of chip select rising. A stale or wrongly cleared readback word is exposed on `sdo` during the very next frame. A sequencer stuck outside idle would miss the next frame's pulse, and that shows on the following register check. Output-enable faults appear within the same frame as a mismatch on `sdo_oe`.

// File: rtl/spi_rs_pkg.sv
`timescale 1ns/1ps
package spi_rs_pkg;
    localparam int FRAME_BITS  = 24;
    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 7;
    localparam int FIXED_REGS  = 3;
    localparam int CFG_SDO_EN  = 2;
    localparam int CFG_PDN     = 5;
    localparam logic [ADDR_W-1:0] CFG_ADDR = 7'h03;
    localparam logic [ADDR_W-1:0] GEN_ADDR = 7'h04;
    localparam logic [ADDR_W-1:0] PWD_ADDR = 7'h09;
    localparam logic [WORD_W-1:0] CFG_RST  = 16'h0A24;
    localparam logic [WORD_W-1:0] GEN_RST  = 16'h7F00;
    localparam logic [WORD_W-1:0] PWD_RST  = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_APPLY = 2'd2
    } seq_t;
endpackage

// File: rtl/spi_rs_shift.sv
`timescale 1ns/1ps
module spi_rs_shift
    import spi_rs_pkg::*;
(
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  sdi,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  sdo_bit,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  frame_tog
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0]      edge_cnt;
    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      out_idx;

    // edge counter, cleared while the frame select is high
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            edge_cnt <= '0;
        end else if (edge_cnt != CNT_SAT) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    always_ff @(negedge sclk) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], sdi};
    end

    // accept only frames with exactly FRAME_BITS falling edges
    always_ff @(posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            frame_word <= '0;
            frame_tog  <= 1'b0;
        end else if (edge_cnt == CNT_FULL) begin
            frame_word <= shift_q;
            frame_tog  <= ~frame_tog;
        end
    end

    assign out_idx = CNT_LAST - edge_cnt;

    always_comb begin
        if (edge_cnt < CNT_FULL) begin
            sdo_bit = tx_word[out_idx];
        end else begin
            sdo_bit = 1'b0;
        end
    end
endmodule

// File: rtl/spi_rs_sync.sv
`timescale 1ns/1ps
module spi_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], tog_in};
        end
    end

    assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/spi_rs_regbank.sv
`timescale 1ns/1ps
module spi_rs_regbank
    import spi_rs_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter logic [ADDR_W-1:0] DATA_BASE = 7'h14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    output logic [WORD_W-1:0]               rdata,
    output logic                            hit,
    output logic [(FIXED_REGS+NUM_CH)*WORD_W-1:0] regs_flat
);
    localparam int NREG = FIXED_REGS + NUM_CH;

    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        if (s == 0)      return CFG_ADDR;
        else if (s == 1) return GEN_ADDR;
        else if (s == 2) return PWD_ADDR;
        else             return DATA_BASE + ADDR_W'(s - FIXED_REGS);
    endfunction

    function automatic logic [WORD_W-1:0] slot_rst(input int s);
        if (s == 0)      return CFG_RST;
        else if (s == 1) return GEN_RST;
        else if (s == 2) return PWD_RST;
        else             return '0;
    endfunction

    logic [NREG-1:0] sel;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_A   = slot_addr(g);
        localparam logic [WORD_W-1:0] SLOT_RST = slot_rst(g);
        logic [WORD_W-1:0] q;

        assign sel[g] = (addr == SLOT_A);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= SLOT_RST;
            end else if (wr_en && sel[g]) begin
                q <= wdata;
            end
        end

        assign regs_flat[g*WORD_W +: WORD_W] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) rdata = rdata | regs_flat[i*WORD_W +: WORD_W];
        end
    end

    assign hit = |sel;
endmodule

// File: rtl/spi_rs_slave.sv
`timescale 1ns/1ps
module spi_rs_slave
    import spi_rs_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter logic [ADDR_W-1:0] DATA_BASE = 7'h14
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sclk,
    input  logic                                cs_n,
    input  logic                                sdi,
    output logic                                sdo,
    output logic                                sdo_oe,
    output logic [(FIXED_REGS+NUM_CH)*WORD_W-1:0] regs_o,
    output logic                                dev_active
);
    localparam int NREG   = FIXED_REGS + NUM_CH;
    localparam int REGS_W = NREG * WORD_W;

    logic [FRAME_BITS-1:0] frame_word;
    logic                  frame_tog;
    logic                  frame_pulse;
    logic [FRAME_BITS-1:0] cmd_q;
    logic [FRAME_BITS-1:0] rd_word;
    logic [WORD_W-1:0]     bank_rdata;
    logic                  bank_hit;
    logic                  wr_en;
    seq_t                  st_q, st_d;

    spi_rs_shift u_shift (
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .tx_word    (rd_word),
        .sdo_bit    (sdo),
        .frame_word (frame_word),
        .frame_tog  (frame_tog)
    );

    spi_rs_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_in (frame_tog),
        .pulse  (frame_pulse)
    );

    spi_rs_regbank #(.NUM_CH(NUM_CH), .DATA_BASE(DATA_BASE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (cmd_q[FRAME_BITS-2 -: ADDR_W]),
        .wdata     (cmd_q[WORD_W-1:0]),
        .rdata     (bank_rdata),
        .hit       (bank_hit),
        .regs_flat (regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (frame_pulse) st_d = ST_LATCH;
            ST_LATCH: st_d = ST_APPLY;
            ST_APPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            rd_word <= '0;
        end else begin
            unique case (st_q)
                ST_LATCH: cmd_q <= frame_word;
                ST_APPLY: begin
                    if (cmd_q[FRAME_BITS-1]) begin
                        rd_word <= {cmd_q[FRAME_BITS-1:WORD_W], bank_rdata};
                    end else begin
                        rd_word <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_en      = (st_q == ST_APPLY) && !cmd_q[FRAME_BITS-1];
    assign sdo_oe     = !cs_n && regs_o[CFG_SDO_EN];
    assign dev_active = !regs_o[CFG_PDN];

    logic unused_w;
    assign unused_w = ^{REGS_W};
endmodule

// File: rtl/spi_rs_slave_chk.sv
`timescale 1ns/1ps
module spi_rs_slave_chk
    import spi_rs_pkg::*;
#(
    parameter int REGS_W = 112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo_oe,
    input logic              dev_active,
    input logic [REGS_W-1:0] regs_o,
    input seq_t              st_q,
    input logic              frame_pulse,
    input logic              wr_en,
    input logic              bank_hit
);
    // R8: pad driver released whenever the frame select is high
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

    // R3: registers change only in the apply step
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_APPLY) |=> $stable(regs_o));

    // R7: a write to an unmapped address leaves the bank untouched
    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_APPLY && wr_en && !bank_hit) |=> $stable(regs_o));

    // R9: activation only follows an applied frame
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_active) |-> ($past(st_q) == ST_APPLY));

    // R4: a new frame never arrives while one is being decoded
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (st_q == ST_IDLE));
endmodule

bind spi_rs_slave spi_rs_slave_chk #(.REGS_W(REGS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sdo_oe      (sdo_oe),
    .dev_active  (dev_active),
    .regs_o      (regs_o),
    .st_q        (st_q),
    .frame_pulse (frame_pulse),
    .wr_en       (wr_en),
    .bank_hit    (bank_hit)
);

// File: tb/spi_rs_slave_tb.sv
`timescale 1ns/1ps
module spi_rs_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, dev_active;
    logic [111:0] regs_o;

    int total = 0;
    int bad = 0;

    logic [15:0] m_regs [128];
    logic [23:0] pend;

    always #5 clk = ~clk;

    spi_rs_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .regs_o     (regs_o),
        .dev_active (dev_active)
    );

    function automatic bit mapped(input int a);
        return (a == 3) || (a == 4) || (a == 9) || (a >= 'h14 && a <= 'h17);
    endfunction

    // R10 slice order
    function automatic logic [111:0] model_bus();
        logic [111:0] b;
        b[15:0]  = m_regs[3];
        b[31:16] = m_regs[4];
        b[47:32] = m_regs[9];
        for (int c = 0; c < 4; c++) b[48+16*c +: 16] = m_regs['h14 + c];
        return b;
    endfunction

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 128; a++) m_regs[a] = 16'h0000;
        m_regs[3] = 16'h0A24;
        m_regs[4] = 16'h7F00;
        m_regs[9] = 16'hFFFF;
        pend = 24'h0;
    endtask

    task automatic run_frame(input bit cpol, input int nbits,
                             input logic [23:0] word, input string tag);
        logic [23:0] cap, mask, exp_sdo;
        bit exp_oe, oe_ok;
        int a;
        exp_oe = m_regs[3][2];
        exp_sdo = pend;
        cap = '0; mask = '0; oe_ok = 1'b1;
        sclk = cpol;
        #40;
        cs_n = 1'b0;
        #20;
        if (sdo_oe !== exp_oe) oe_ok = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 24) ? word[23-i] : 1'b0;
            if (!cpol) begin sclk = 1'b1; #20; end
            if (i < 24) begin cap[23-i] = sdo; mask[23-i] = 1'b1; end
            if (sdo_oe !== exp_oe) oe_ok = 1'b0;
            sclk = 1'b0; #20;
            if (cpol) begin sclk = 1'b1; #20; end
        end
        #20;
        cs_n = 1'b1;
        #2;
        check(sdo_oe == 1'b0, {"R8 oe after frame ", tag}, sdo_oe, 0);
        repeat (10) @(posedge clk);
        #1;
        check(oe_ok, {"R8 oe during frame ", tag}, !oe_ok, 0);
        if (exp_oe && nbits > 0)
            check((cap & mask) == (exp_sdo & mask), {"R5/R6 readback ", tag},
                  cap & mask, exp_sdo & mask);
        if (nbits == 24) begin
            a = int'(word[22:16]);
            if (word[23]) begin
                pend = {word[23:16], mapped(a) ? m_regs[a] : 16'h0000};
            end else begin
                pend = 24'h0;
                if (mapped(a)) m_regs[a] = word[15:0];
            end
        end
        check(regs_o == model_bus(), {"R3/R4/R7 regs ", tag}, regs_o, model_bus());
        check(dev_active == !m_regs[3][5], {"R9 active ", tag}, dev_active, !m_regs[3][5]);
    endtask

    initial begin
        #1500000;
        bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd7741);
        model_reset();
        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(regs_o == model_bus(), "R2 reset regs", regs_o, model_bus());
        check(dev_active == 1'b0, "R2 reset active", dev_active, 0);
        check(sdo_oe == 1'b0, "R2 reset oe", sdo_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R9 wake-up, R11 both clock polarities
        run_frame(1'b0, 24, {1'b0, 7'h03, 16'h0A84}, "wake mode1");
        run_frame(1'b1, 24, {1'b1, 7'h03, 16'h5555}, "read cfg mode2");
        // R7 write to unmapped address, carries the cfg readback (R5)
        run_frame(1'b0, 24, {1'b0, 7'h00, 16'h1234}, "unmapped write");
        run_frame(1'b1, 24, {1'b0, 7'h15, 16'hBEEF}, "data write R6");
        run_frame(1'b0, 24, {1'b1, 7'h15, 16'h0000}, "data read");
        // R4 short and long frames are dropped, readback stays pending
        run_frame(1'b1, 23, {1'b0, 7'h15, 16'h1111}, "short R4");
        run_frame(1'b0, 25, {1'b0, 7'h16, 16'h2222}, "long R4");
        run_frame(1'b1, 0,  24'h0, "empty R4");
        run_frame(1'b0, 24, {1'b1, 7'h7F, 16'hFFFF}, "unmapped read R7");
        run_frame(1'b1, 24, {1'b0, 7'h17, 16'hA5A5}, "after unmapped read");
        // R8 output enable cleared, then restored
        run_frame(1'b0, 24, {1'b0, 7'h03, 16'h0A80}, "oe off");
        run_frame(1'b1, 24, {1'b1, 7'h04, 16'h0000}, "oe off frame");
        run_frame(1'b0, 24, {1'b0, 7'h03, 16'h0A84}, "oe on");

        for (int n = 0; n < 150; n++) begin
            bit cp;
            int len, r, a;
            logic [15:0] d;
            cp = 1'($urandom % 2);
            r = $urandom % 10;
            if (r < 8) len = 24;
            else if (r == 8) len = 23;
            else len = 25 + ($urandom % 4);
            if (($urandom % 10) < 7) begin
                case ($urandom % 7)
                    0: a = 3;
                    1: a = 4;
                    2: a = 9;
                    default: a = 'h14 + ($urandom % 4);
                endcase
            end else begin
                a = $urandom % 128;
            end
            d = 16'($urandom);
            if (a == 3) d[2] = 1'b1;
            run_frame(cp, len, {1'($urandom % 2), 7'(a), d}, "random R1 R11");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule